// File: doc/BRIEF.md
# DRAM Command Sequencer

This block decides which command an eight-bank DRAM controller sends to its PHY in each clock cycle. After reset it holds off all traffic while the PHY brings up and calibrates the memory. A calibration-pass input opens the gate into the operational state. A calibration-fail input locks the block into a failure state until the next reset.

In the operational state an internal timer raises a refresh demand at a fixed parametric interval. Refresh always wins over user traffic. While a refresh is outstanding, reads and writes stall, and the refresh goes out once every bank reports ready. A read or write is taken through a valid/ready handshake. It is accepted in any cycle with no outstanding refresh in which its target bank is ready and the data-bus ready flag is set. Accepted work appears on a registered command port one cycle later.

The per-bank and data-bus readiness come from an external timer block. The PHY, the data FIFOs and burst splitting sit outside this block.

Top module: `dram_cmd_sequencer`

## Requirements
- R1: During and right after a synchronous reset, cmd_valid_o, req_ready_o, init_done_o and init_fail_o are all low.
- R2: The block stays uninitialised while neither calibration input is high. init_done_o rises in the cycle after cal_pass_i is sampled high, provided cal_fail_i is low in that cycle.
- R3: When cal_fail_i is sampled high in the uninitialised state, init_fail_o rises in the next cycle, even if cal_pass_i is high in the same cycle. init_fail_o then stays high and init_done_o stays low until reset.
- R4: Outside the operational state, req_ready_o is low and no command is issued.
- R5: With every bank ready and no user traffic, the first refresh command appears REF_INTERVAL+1 cycles after init_done_o rises. Later refresh commands follow at a spacing of REF_INTERVAL+1 cycles.
- R6: While a refresh is outstanding, req_ready_o is low and no read or write is issued, whatever the state of the request and the readiness inputs.
- R7: An outstanding refresh is issued only in a cycle in which all bank_ready_i bits are high. It appears the next cycle as cmd_code_o = 3 with cmd_bank_o and cmd_addr_o zero.
- R8: With no refresh outstanding in the operational state, req_ready_o equals bank_ready_i[req_bank_i] AND bus_ready_i. Each accepted request appears the next cycle with cmd_valid_o high, cmd_code_o = 1 for a read or 2 for a write (req_write_i high), and the request's bank and address.
- R9: In a cycle following one in which nothing was issued, cmd_valid_o is low and cmd_code_o, cmd_bank_o and cmd_addr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_pass_i | input | 1 | PHY reports calibration success |
| cal_fail_i | input | 1 | PHY reports calibration failure |
| req_valid_i | input | 1 | Read/write request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank of the request |
| req_addr_i | input | ADDR_W | Row/column address of the request |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| bank_ready_i | input | NUM_BANKS | Per-bank timing satisfied |
| bus_ready_i | input | 1 | Data-bus turnaround timing satisfied |
| cmd_valid_o | output | 1 | Command valid towards the PHY |
| cmd_code_o | output | 2 | 0 none, 1 read, 2 write, 3 refresh |
| cmd_bank_o | output | BANK_W | Bank of the issued command |
| cmd_addr_o | output | ADDR_W | Address of the issued command |
| init_done_o | output | 1 | Operational state reached |
| init_fail_o | output | 1 | Calibration failed, terminal |

## Verification
The bench builds the block with eight banks, a 10-bit address and REF_INTERVAL set to 20, far below a realistic default. This short interval makes refresh demands arrive every few dozen cycles. Random request traffic and randomly withheld bank and bus readiness then collide with them hundreds of times, so refresh pre-emption, refresh waiting on a busy bank, and a request stalled behind a refresh all occur often. Directed phases cover simultaneous pass and fail pulses, a pass pulse arriving after failure, and the exact refresh spacing on an idle bus.

// File: rtl/dram_cmdseq_pkg.sv
package dram_cmdseq_pkg;

  typedef enum logic [1:0] {
    ST_UNINIT = 2'd0,
    ST_OPER   = 2'd1,
    ST_FAILED = 2'd2
  } cal_state_t;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_READ    = 2'd1,
    OP_WRITE   = 2'd2,
    OP_REFRESH = 2'd3
  } op_code_t;

endpackage

// File: rtl/cmdseq_cal_gate.sv
module cmdseq_cal_gate
  import dram_cmdseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cal_pass_i,
  input  logic cal_fail_i,
  output logic oper_o,
  output logic failed_o
);

  cal_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_UNINIT;
    end else begin
      case (state_q)
        ST_UNINIT: begin
          if (cal_fail_i)      state_q <= ST_FAILED;
          else if (cal_pass_i) state_q <= ST_OPER;
        end
        ST_OPER:   state_q <= ST_OPER;
        ST_FAILED: state_q <= ST_FAILED;
        default:   state_q <= ST_UNINIT;
      endcase
    end
  end

  assign oper_o   = (state_q == ST_OPER);
  assign failed_o = (state_q == ST_FAILED);

  AST_FAIL_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    failed_o |=> (failed_o && !oper_o)); // R3
  AST_WAIT_FOR_CAL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UNINIT && !cal_pass_i && !cal_fail_i) |=> (state_q == ST_UNINIT)); // R2
  AST_FAIL_WINS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UNINIT && cal_fail_i) |=> failed_o); // R3

endmodule

// File: rtl/cmdseq_ref_timer.sv
module cmdseq_ref_timer #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic take_i,
  output logic pend_o
);

  localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (take_i) pend_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !take_i && run_i) |=> pend_o); // R6
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !pend_o); // R5

endmodule

// File: rtl/cmdseq_arbiter.sv
module cmdseq_arbiter
  import dram_cmdseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 20,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 oper_i,
  input  logic                 ref_pend_i,
  input  logic [NUM_BANKS-1:0] bank_ready_i,
  input  logic                 bus_ready_i,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 req_ready_o,
  output logic                 ref_take_o,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_code_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [ADDR_W-1:0]    cmd_addr_o
);

  logic all_banks_ok;
  logic tgt_bank_ok;
  logic rw_open;
  logic rw_take;

  assign all_banks_ok = &bank_ready_i;
  assign tgt_bank_ok  = bank_ready_i[req_bank_i];
  assign ref_take_o   = oper_i && ref_pend_i && all_banks_ok;
  assign rw_open      = oper_i && !ref_pend_i && tgt_bank_ok && bus_ready_i;
  assign rw_take      = rw_open && req_valid_i;
  assign req_ready_o  = rw_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= OP_NONE;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
    end else if (ref_take_o) begin
      cmd_valid_o <= 1'b1;
      cmd_code_o  <= OP_REFRESH;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
    end else if (rw_take) begin
      cmd_valid_o <= 1'b1;
      cmd_code_o  <= req_write_i ? OP_WRITE : OP_READ;
      cmd_bank_o  <= req_bank_i;
      cmd_addr_o  <= req_addr_i;
    end else begin
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= OP_NONE;
      cmd_bank_o  <= '0;
      cmd_addr_o  <= '0;
    end
  end

  AST_REF_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_code_o == OP_REFRESH) |-> $past(all_banks_ok)); // R7
  AST_RW_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && (cmd_code_o == OP_READ || cmd_code_o == OP_WRITE)) |-> $past(bus_ready_i)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_o |-> (cmd_code_o == OP_NONE && cmd_addr_o == '0)); // R9

endmodule

// File: rtl/dram_cmd_sequencer.sv
module dram_cmd_sequencer
  import dram_cmdseq_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int ADDR_W       = 20,
  parameter int REF_INTERVAL = 1560,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_pass_i,
  input  logic                 cal_fail_i,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 req_ready_o,
  input  logic [NUM_BANKS-1:0] bank_ready_i,
  input  logic                 bus_ready_i,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_code_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [ADDR_W-1:0]    cmd_addr_o,
  output logic                 init_done_o,
  output logic                 init_fail_o
);

  logic oper;
  logic ref_pend;
  logic ref_take;

  cmdseq_cal_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .cal_pass_i (cal_pass_i),
    .cal_fail_i (cal_fail_i),
    .oper_o     (oper),
    .failed_o   (init_fail_o)
  );

  cmdseq_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (oper),
    .take_i (ref_take),
    .pend_o (ref_pend)
  );

  cmdseq_arbiter #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .oper_i       (oper),
    .ref_pend_i   (ref_pend),
    .bank_ready_i (bank_ready_i),
    .bus_ready_i  (bus_ready_i),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_bank_i   (req_bank_i),
    .req_addr_i   (req_addr_i),
    .req_ready_o  (req_ready_o),
    .ref_take_o   (ref_take),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_code_o   (cmd_code_o),
    .cmd_bank_o   (cmd_bank_o),
    .cmd_addr_o   (cmd_addr_o)
  );

  assign init_done_o = oper;

  AST_QUIET_OUTSIDE_OPER: assert property (@(posedge clk) disable iff (rst)
    !oper |=> !cmd_valid_o); // R4
  AST_REF_BLOCKS_RW: assert property (@(posedge clk) disable iff (rst)
    ref_pend |=> !(cmd_valid_o && (cmd_code_o == OP_READ || cmd_code_o == OP_WRITE))); // R6
  AST_NO_READY_OUTSIDE_OPER: assert property (@(posedge clk) disable iff (rst)
    (init_fail_o || !init_done_o) |-> !req_ready_o); // R4

endmodule

// File: tb/test_dram_cmd_sequencer.sv
module test_dram_cmd_sequencer;

  localparam int NB   = 8;
  localparam int AW   = 10;
  localparam int RI   = 20;
  localparam int BW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cal_pass = 1'b0, cal_fail = 1'b0;
  logic          rq_valid = 1'b0, rq_write = 1'b0;
  logic [BW-1:0] rq_bank = '0;
  logic [AW-1:0] rq_addr = '0;
  logic [NB-1:0] bk_rdy = '1;
  logic          bus_rdy = 1'b1;
  logic          req_ready, cmd_valid, init_done, init_fail;
  logic [1:0]    cmd_code;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;

  always #4 clk = ~clk;

  dram_cmd_sequencer #(.NUM_BANKS(NB), .ADDR_W(AW), .REF_INTERVAL(RI)) i_dram_cmd_sequencer (
    .clk(clk), .rst(rst), .cal_pass_i(cal_pass), .cal_fail_i(cal_fail),
    .req_valid_i(rq_valid), .req_write_i(rq_write), .req_bank_i(rq_bank),
    .req_addr_i(rq_addr), .req_ready_o(req_ready), .bank_ready_i(bk_rdy),
    .bus_ready_i(bus_rdy), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr), .init_done_o(init_done),
    .init_fail_o(init_fail)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // Reference model: 0 uninit, 1 operational, 2 failed
  int          m_st = 0, m_cnt = 0;
  bit          m_pend = 0;
  bit          e_valid = 0;
  int          e_code = 0, e_bank = 0, e_addr = 0;
  string       e_tag = "R1";

  function automatic bit exp_ready();
    return (m_st == 1) && !m_pend && bk_rdy[rq_bank] && bus_rdy;
  endfunction

  function automatic string ready_tag();
    if (m_st != 1) return "R4";
    if (m_pend) return "R6";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pend = 0;
      e_valid = 0; e_code = 0; e_bank = 0; e_addr = 0; e_tag = "R1";
    end else begin
      bit take_ref, take_rw;
      take_ref = (m_st == 1) && m_pend && (&bk_rdy);
      take_rw  = exp_ready() && rq_valid;
      if (m_st != 1)     e_tag = "R4";
      else if (take_ref) e_tag = "R7";
      else if (m_pend)   e_tag = "R6";
      else if (take_rw)  e_tag = "R8";
      else               e_tag = "R9";
      e_valid = take_ref || take_rw;
      e_code  = take_ref ? 3 : take_rw ? (rq_write ? 2 : 1) : 0;
      e_bank  = take_rw && !take_ref ? int'(rq_bank) : 0;
      e_addr  = take_rw && !take_ref ? int'(rq_addr) : 0;
      if (m_st == 1) begin
        if (m_pend) begin
          if (take_ref) m_pend = 0;
        end else if (m_cnt == RI - 1) begin
          m_pend = 1; m_cnt = 0;
        end else m_cnt++;
      end else begin
        m_pend = 0; m_cnt = 0;
      end
      if (m_st == 0) begin
        if (cal_fail) m_st = 2;
        else if (cal_pass) m_st = 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    chk(e_tag, "cmd_valid", int'(cmd_valid), int'(e_valid));
    chk(e_tag, "cmd_code", int'(cmd_code), e_code);
    chk(e_tag, "cmd_bank", int'(cmd_bank), e_bank);
    chk(e_tag, "cmd_addr", int'(cmd_addr), e_addr);
    chk(rst ? "R1" : "R2", "init_done", int'(init_done), int'(m_st == 1));
    chk(rst ? "R1" : "R3", "init_fail", int'(init_fail), int'(m_st == 2));
    chk(rst ? "R1" : ready_tag(), "req_ready", int'(req_ready), int'(exp_ready()));
  endtask

  task automatic randomize_inputs();
    rq_valid = ($urandom % 2) == 0;
    rq_write = $urandom % 2;
    rq_bank  = BW'($urandom);
    rq_addr  = AW'($urandom);
    for (int b = 0; b < NB; b++) bk_rdy[b] = ($urandom % 8) != 0;
    bus_rdy  = ($urandom % 4) != 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cal_pass = 0; cal_fail = 0; rq_valid = 0;
    repeat (3) cycle();
    chk("R1", "reset cmd_valid", int'(cmd_valid), 0);
    chk("R1", "reset req_ready", int'(req_ready), 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int t_done, r0, r1;
    void'($urandom(32'd2718));

    // R1, R2, R4: hold uninitialised with traffic offered
    do_reset();
    for (int i = 0; i < 8; i++) begin randomize_inputs(); rq_valid = 1; cycle(); end
    chk("R2", "still uninit", int'(init_done), 0);

    // R2: pass pulse, then random traffic (R5..R9)
    cal_pass = 1; cycle(); cal_pass = 0;
    for (int i = 0; i < 3000; i++) begin randomize_inputs(); cycle(); end

    // R3: simultaneous pass and fail, then late pass pulse
    do_reset();
    cal_pass = 1; cal_fail = 1; cycle();
    cal_pass = 0; cal_fail = 0; cycle();
    chk("R3", "fail wins", int'(init_fail), 1);
    for (int i = 0; i < 30; i++) begin
      randomize_inputs(); cal_pass = (i % 3) == 0; cycle();
    end
    cal_pass = 0;
    chk("R3", "fail terminal", int'(init_fail), 1);
    chk("R3", "never done", int'(init_done), 0);

    // R5: exact refresh spacing on an idle bus
    do_reset();
    bk_rdy = '1; bus_rdy = 1; rq_valid = 0;
    cal_pass = 1; cycle(); cal_pass = 0;
    t_done = -1; r0 = -1; r1 = -1;
    for (int i = 0; i < 3 * RI; i++) begin
      if (init_done && t_done < 0) t_done = cyc;
      if (cmd_valid && cmd_code == 2'd3) begin
        if (r0 < 0) r0 = cyc; else if (r1 < 0) r1 = cyc;
      end
      cycle();
    end
    chk("R5", "first refresh delay", r0 - t_done, RI + 1);
    chk("R5", "refresh spacing", r1 - r0, RI + 1);

    // R6, R7: constant request while refresh blocked by one busy bank
    rq_valid = 1; rq_bank = 3'd2; bus_rdy = 1;
    for (int i = 0; i < 2 * RI; i++) begin
      bk_rdy = (i % 5 == 0) ? 8'hFF : 8'hF7;
      cycle();
    end
    for (int i = 0; i < 500; i++) begin randomize_inputs(); cycle(); end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule